// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system use an external asynchronous static RAM of 1M words by 4 bits. The RAM has 20 address lines, a 4-bit data bus and three active-low strobes: chip select, write strobe and output enable. On the user side a request is presented with `req_valid`, a write flag, an address and write data, and is taken on a clock edge where `req_ready` is high. Each request becomes a fixed sequence of registered pin states. Every phase of that sequence lasts a number of clock cycles derived from the clock period and the RAM's nanosecond limits.

A write drives address and data first. It then pulls the write strobe low with chip select already low, and ends the write by raising the write strobe alone. Address, chip select and data drive stay put for at least one more cycle. Output enable stays high for the whole write, so the RAM never competes for the bus. A read lowers chip select and output enable with the write strobe high. It waits out the access time plus a synchroniser margin and captures the bus on the edge that ends that wait. It then returns `rsp_valid` for one cycle and holds every strobe high for a turn-around period before the next request can drive the bus.

The data bus is split into output value, output enable and input value, so the tristate pad can sit in the chip's I/O ring.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset the chip select, write strobe and output enable are all high, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0. The same quiet pin state holds whenever `req_ready` is 1.
- R2: A write first holds chip select low with the write strobe high for SETUP cycles while driving address and data. It then holds the write strobe low for exactly WPULSE cycles. During that pulse chip select stays low, output enable stays high, and `sram_dq_oe` and `sram_dq_o` stay constant.
- R3: A write ends only by the write strobe rising. Chip select, the address and the data drive then stay unchanged for HOLD more cycles.
- R4: Data written to an address is returned by a later read of that address, at any address from 0 to 0xFFFFF and for data values 0x0 and 0xF.
- R5: A read holds chip select and output enable low, with the write strobe high and `sram_dq_oe` low, for exactly ACCESS cycles. The capture takes `sram_dq_i` as it stands just before the edge that ends this phase.
- R6: `rsp_valid` pulses for exactly one cycle per read, in the cycle right after the access phase ends, with the captured value on `rsp_rdata`. A write never produces it.
- R7: `req_ready` falls on the edge after acceptance and stays low for SETUP+WPULSE+HOLD cycles for a write and ACCESS+TURN cycles for a read. A `req_valid` raised while `req_ready` is low has no effect.
- R8: `sram_dq_oe` is never high while output enable is low, nor in the cycle after output enable was low. Every read is followed by TURN cycles with all strobes high.
- R9: Output enable and the write strobe are never low in the same cycle.
- R10: The address pins do not change while chip select stays low.
- R11: Each phase count is ceil(t_ps / CLK_PS), with a floor of 1. SETUP comes from address setup. WPULSE is the larger of the write-pulse and data-setup counts. HOLD comes from data hold. ACCESS is the access-time count plus RD_SYNC_CYC. TURN comes from the output-disable time. At CLK_PS=4000 with 0/7000/5000/0/10000/5000 ps and RD_SYNC_CYC=1, this gives SETUP=1, WPULSE=2, HOLD=1, ACCESS=4 and TURN=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | DATA_W | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | DATA_W | Value sampled from the data bus |

## Verification
The bound checker covers, on every cycle, the rules between pins. These are the quiet idle state, write strobe only under chip select with output enable high, constant data during the pulse, held address and drive after the write strobe rises, no drive during or just after an output enable, and the one-cycle completion pulse. Only the bench's scenarios can show the exact phase lengths, the data actually stored and returned, the capture instant against a RAM model whose data turns valid late, and that a request arriving while busy is dropped.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes all times are given in picoseconds as non-negative integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_e;

    // Cycles needed to cover t_ps at clk_ps, rounded up, never below one.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                              input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one phase of a RAM access.
// Loading N gives expiry after N further edges; expired is high at count zero.
// Assumes load is only pulsed when the sequencer changes phase.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: turns accepted requests into registered strobe states.
// Every pin level is registered from the next phase, so strobes never glitch.
// Assumes each phase count parameter is at least one.
module sram_seq_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned CNT_W      = 3,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned WPULSE_CYC = 1,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 2,
    parameter int unsigned TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              wr_accept,
    output logic              rd_capture,
    output logic              ready,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_ce_n,
    output logic              pin_we_n,
    output logic              pin_oe_n,
    output logic              pin_drive
);

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC  - 1);
    localparam logic [CNT_W-1:0] LD_WPULSE = CNT_W'(WPULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC   - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC   - 1);

    phase_e ph_q, ph_d;
    logic   accept;

    // Next-phase selection and timer reload on each phase change.
    always_comb begin
        ph_d       = ph_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        rd_capture = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid && ready) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        ph_d    = PH_WSETUP;
                        tmr_val = LD_SETUP;
                    end else begin
                        ph_d    = PH_RACC;
                        tmr_val = LD_ACCESS;
                    end
                end
            end
            PH_WSETUP: begin
                if (tmr_expired) begin
                    ph_d     = PH_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WPULSE;
                end
            end
            PH_WPULSE: begin
                if (tmr_expired) begin
                    ph_d     = PH_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            PH_WHOLD: begin
                if (tmr_expired) begin
                    ph_d = PH_IDLE;
                end
            end
            PH_RACC: begin
                if (tmr_expired) begin
                    ph_d       = PH_RTURN;
                    rd_capture = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_TURN;
                end
            end
            PH_RTURN: begin
                if (tmr_expired) begin
                    ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    assign wr_accept = accept && req_write;

    // Phase register plus strobe levels registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            ready     <= 1'b1;
            pin_ce_n  <= 1'b1;
            pin_we_n  <= 1'b1;
            pin_oe_n  <= 1'b1;
            pin_drive <= 1'b0;
        end else begin
            ph_q      <= ph_d;
            ready     <= (ph_d == PH_IDLE);
            pin_ce_n  <= !(ph_d == PH_WSETUP || ph_d == PH_WPULSE ||
                           ph_d == PH_WHOLD  || ph_d == PH_RACC);
            pin_we_n  <= (ph_d != PH_WPULSE);
            pin_oe_n  <= (ph_d != PH_RACC);
            pin_drive <= (ph_d == PH_WSETUP || ph_d == PH_WPULSE ||
                          ph_d == PH_WHOLD);
        end
    end

    // Address register: loaded on acceptance only, so it holds across a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_addr <= '0;
        end else if (accept) begin
            pin_addr <= req_addr;
        end
    end

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
// Data path for the split tristate bus: holds write data, drives the pad
// enable from the sequencer, captures read data and raises the completion pulse.
// Assumes the pad ring resolves dq_o/dq_oe into the physical bus.
module sram_dq_path #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Write data register, loaded only when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o <= '0;
        end else if (wr_accept) begin
            dq_o <= wdata;
        end
    end

    // Read capture and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_i;
            end
        end
    end

    assign dq_oe = drive;

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Derives phase counts from the
// clock period and RAM limits, then joins the timer, sequencer and data path.
// Assumes one outstanding request at a time and a pad-split data bus.
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned DATA_W      = 4,
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned T_ASU_PS    = 0,
    parameter int unsigned T_WP_PS     = 7000,
    parameter int unsigned T_DSU_PS    = 5000,
    parameter int unsigned T_DH_PS     = 0,
    parameter int unsigned T_ACC_PS    = 10000,
    parameter int unsigned T_HZ_PS     = 5000,
    parameter int unsigned RD_SYNC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int unsigned SETUP_CYC  = ps_to_cyc(T_ASU_PS, CLK_PS);
    localparam int unsigned WPULSE_CYC = max2(ps_to_cyc(T_WP_PS, CLK_PS),
                                              ps_to_cyc(T_DSU_PS, CLK_PS));
    localparam int unsigned HOLD_CYC   = ps_to_cyc(T_DH_PS, CLK_PS);
    localparam int unsigned ACCESS_CYC = ps_to_cyc(T_ACC_PS, CLK_PS) + RD_SYNC_CYC;
    localparam int unsigned TURN_CYC   = ps_to_cyc(T_HZ_PS, CLK_PS);
    localparam int unsigned MAX_CYC    = max2(max2(SETUP_CYC, WPULSE_CYC),
                                              max2(max2(HOLD_CYC, ACCESS_CYC), TURN_CYC));
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             wr_accept;
    logic             rd_capture;
    logic             drive;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .WPULSE_CYC (WPULSE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .TURN_CYC   (TURN_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .wr_accept   (wr_accept),
        .rd_capture  (rd_capture),
        .ready       (req_ready),
        .pin_addr    (sram_addr),
        .pin_ce_n    (sram_ce_n),
        .pin_we_n    (sram_we_n),
        .pin_oe_n    (sram_oe_n),
        .pin_drive   (drive)
    );

    sram_dq_path #(
        .DATA_W (DATA_W)
    ) dq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wdata     (req_wdata),
        .drive     (drive),
        .capture   (rd_capture),
        .dq_i      (sram_dq_i),
        .dq_o      (sram_dq_o),
        .dq_oe     (sram_dq_oe),
        .rd_data   (rsp_rdata),
        .rd_valid  (rsp_valid)
    );

endmodule

// File: rtl/sram_async_ctl_chk.sv
`timescale 1ns/1ps
// Pin-level protocol checker for the asynchronous SRAM controller.
// Assumes it is bound to sram_async_ctl and sees only its ports.
module sram_async_ctl_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [DATA_W-1:0] sram_dq_o,
    input logic              sram_dq_oe
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    p_pulse_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    p_pulse_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_dq_o));

    p_hold_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr)
                              && $stable(sram_dq_o)));

    p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_ce_n));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n)));

    p_no_oe_we_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
// Directed bench with a cycle-level RAM model; one task per scenario.
module sram_async_ctl_tb_top;

    localparam int CLK_NS = 4;
    // R11: at 4000 ps clock -> SETUP=1, WPULSE=ceil(7/4)=2, HOLD=1,
    // ACCESS=ceil(10/4)+1=4, TURN=ceil(5/4)=2.
    localparam int EXP_SETUP  = 1;
    localparam int EXP_WPULSE = 2;
    localparam int EXP_HOLD   = 1;
    localparam int EXP_ACCESS = 4;
    localparam int EXP_TURN   = 2;
    // Model: data valid only after 3 full cycles (12 ns >= 10 ns) of stable read.
    localparam int MDL_ACC    = 3;
    localparam int MDL_WMIN   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready;
    logic [3:0]  rsp_rdata;
    logic        rsp_valid;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    logic [3:0]  sram_dq_o;
    logic        sram_dq_oe;
    logic [3:0]  sram_dq_i;

    int n_checks = 0;
    int n_errs   = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctl #(
        .CLK_PS (4000)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ready (req_ready), .rsp_rdata (rsp_rdata), .rsp_valid (rsp_valid),
        .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .sram_dq_o (sram_dq_o), .sram_dq_oe (sram_dq_oe),
        .sram_dq_i (sram_dq_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    logic [3:0]  mem [logic [19:0]];
    logic [3:0]  mdl_q = '0;
    int          rd_cnt = 0;
    logic        rd_en_d = 1'b0;
    int          w_cnt = 0;
    logic [19:0] w_addr = '0;
    logic [3:0]  w_data = '0;
    logic        su_ok = 1'b0;
    logic [19:0] su_addr = '0;
    int          contention = 0;

    function automatic logic [3:0] stored(input logic [19:0] a);
        if (mem.exists(a)) return mem[a];
        return a[3:0] ^ 4'h5;
    endfunction

    wire rd_en = !sram_ce_n && !sram_oe_n && sram_we_n;
    wire wr_on = !sram_ce_n && !sram_we_n;

    assign sram_dq_i = (rd_en && rd_cnt >= MDL_ACC) ? mdl_q : (mdl_q ^ 4'hF);

    // Model: read access counting, write timing checks, contention detection.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && (rd_en || rd_en_d)) contention++;
            rd_en_d <= rd_en;
            rd_cnt  <= rd_en ? rd_cnt + 1 : 0;
            mdl_q   <= stored(sram_addr);
            if (wr_on) begin
                if (w_cnt == 0) begin
                    // R2 address/data setup before the strobe falls
                    check(su_ok && su_addr == sram_addr, "R2 model setup", int'(su_ok), 1);
                    w_addr <= sram_addr;
                    w_data <= sram_dq_o;
                end else begin
                    check(sram_addr == w_addr && sram_dq_o == w_data && sram_dq_oe && sram_oe_n,
                          "R2 model pulse stable", int'(sram_dq_o), int'(w_data));
                end
                w_cnt <= w_cnt + 1;
            end else if (w_cnt != 0) begin
                check(w_cnt >= MDL_WMIN, "R2 model pulse width", w_cnt, MDL_WMIN);
                // R3 hold: address, select and data drive still present
                check(!sram_ce_n && sram_dq_oe && sram_addr == w_addr, "R3 model hold",
                      int'(sram_dq_oe), 1);
                mem[w_addr] = w_data;
                w_cnt <= 0;
            end
            su_ok   <= !sram_ce_n && sram_we_n && sram_dq_oe;
            su_addr <= sram_addr;
        end
    end

    // ---------------- trace of one operation ----------------
    int tr_busy, tr_ce, tr_we, tr_oe, tr_first_we, tr_last_we, tr_last_ce;
    int tr_bad_addr, tr_bad_wr, tr_bad_rd, tr_val, tr_val_k;
    logic [3:0] tr_val_data;

    task automatic run_op(input bit wr, input logic [19:0] a, input logic [3:0] d,
                          input int poke_k, input logic [19:0] poke_a);
        tr_busy = 0; tr_ce = 0; tr_we = 0; tr_oe = 0; tr_first_we = -1; tr_last_we = -1;
        tr_last_ce = -1; tr_bad_addr = 0; tr_bad_wr = 0; tr_bad_rd = 0; tr_val = 0;
        tr_val_k = -1; tr_val_data = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (req_ready) break;
            tr_busy++;
            if (!sram_ce_n) begin
                tr_ce++; tr_last_ce = k;
                if (sram_addr != a) tr_bad_addr++;
            end
            if (!sram_we_n) begin
                tr_we++; tr_last_we = k;
                if (tr_first_we < 0) tr_first_we = k;
                if (sram_ce_n || !sram_dq_oe || !sram_oe_n || sram_dq_o != d) tr_bad_wr++;
            end
            if (!sram_oe_n) begin
                tr_oe++;
                if (sram_dq_oe || !sram_we_n) tr_bad_rd++;
            end
            if (rsp_valid) begin
                tr_val++; tr_val_k = k; tr_val_data = rsp_rdata;
            end
            if (k == poke_k) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = poke_a;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_write(input logic [19:0] a, input logic [3:0] d);
        run_op(1'b1, a, d, -1, '0);
        check(tr_busy == EXP_SETUP + EXP_WPULSE + EXP_HOLD, "R7 write busy", tr_busy,
              EXP_SETUP + EXP_WPULSE + EXP_HOLD);
        check(tr_we == EXP_WPULSE, "R2 R11 pulse length", tr_we, EXP_WPULSE);
        check(tr_first_we == EXP_SETUP, "R2 setup cycles", tr_first_we, EXP_SETUP);
        check(tr_last_ce - tr_last_we == EXP_HOLD, "R3 hold cycles", tr_last_ce - tr_last_we,
              EXP_HOLD);
        check(tr_bad_wr == 0, "R9 R2 pulse framing", tr_bad_wr, 0);
        check(tr_bad_addr == 0, "R10 address", tr_bad_addr, 0);
        check(tr_val == 0, "R6 no valid on write", tr_val, 0);
    endtask

    task automatic t_read(input logic [19:0] a, input logic [3:0] exp);
        run_op(1'b0, a, '0, -1, '0);
        check(tr_busy == EXP_ACCESS + EXP_TURN, "R7 read busy", tr_busy, EXP_ACCESS + EXP_TURN);
        check(tr_oe == EXP_ACCESS, "R5 access length", tr_oe, EXP_ACCESS);
        check(tr_bad_rd == 0 && tr_we == 0, "R5 read strobes", tr_bad_rd, 0);
        check(tr_val == 1 && tr_val_k == EXP_ACCESS, "R6 valid timing", tr_val_k, EXP_ACCESS);
        check(tr_val_data == exp, "R4 R5 read data", int'(tr_val_data), int'(exp));
        check(tr_busy - tr_last_ce - 1 == EXP_TURN, "R8 turnaround", tr_busy - tr_last_ce - 1,
              EXP_TURN);
        check(tr_bad_addr == 0, "R10 address", tr_bad_addr, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes high",
              int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
        check(!sram_dq_oe, "R1 bus released", int'(sram_dq_oe), 0);
        check(req_ready && !rsp_valid, "R1 ready/valid", int'({req_ready, rsp_valid}), 2);
    endtask

    task automatic t_busy_ignore();
        run_op(1'b1, 20'h0ABCD, 4'h6, 1, 20'h00777);
        check(tr_busy == EXP_SETUP + EXP_WPULSE + EXP_HOLD, "R7 busy unchanged by poke",
              tr_busy, EXP_SETUP + EXP_WPULSE + EXP_HOLD);
        repeat (3) begin
            check(req_ready && sram_ce_n && !rsp_valid, "R7 poke ignored",
                  int'({req_ready, sram_ce_n, rsp_valid}), 6);
            @(negedge clk);
        end
        t_read(20'h0ABCD, 4'h6);
    endtask

    task automatic t_read_then_write();
        t_read(20'h00042, 4'h2 ^ 4'h5);
        t_write(20'h00042, 4'h9);
        t_read(20'h00042, 4'h9);
    endtask

    task automatic t_bounds();
        t_write(20'h00000, 4'h0);
        t_write(20'hFFFFF, 4'hF);
        t_read(20'hFFFFF, 4'hF);
        t_read(20'h00000, 4'h0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_errs++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_write(20'h12345, 4'hA);
        t_read(20'h12345, 4'hA);
        t_bounds();
        t_busy_ignore();
        t_read_then_write();
        repeat (4) @(negedge clk);
        check(contention == 0, "R8 model bus contention", contention, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule